// File: doc/BRIEF.md
# Daisy-Chain Serial Result Shifter

This block is the serial output path of a converter that can sit in a chain of converters sharing one data line to the host. While chip select is high it keeps reloading its own held conversion result, framed as a 16-bit word or, with channel tagging on, as a 24-bit word: the result, one channel tag bit, then seven zeros. Once chip select goes low, each serial clock shifts one bit out, MSB first.

In chain mode the status pin acts as a chain input. After the local word has gone out, the bits taken from that input follow one full word later. The next converter downstream therefore sees its upstream neighbour's word right after its own, and three devices need chip select held low for 48 bits. In regular mode, used for the head of the chain, the chain input is ignored and the local word repeats. Pulling chip select high between words reloads the local result, so the host reads the same word again. The held result changes only when a new conversion result is loaded. A converter that skipped a conversion therefore forwards its previous result.

The block has one clock. Each rising edge of `clk` stands for one serial bit step, that is, one active serial clock edge. `chain_en` and `tag_en` are configuration inputs. They must stay stable while `cs_n` is low.

Top module: `chain_out_reg`

## Requirements
- R1: After reset the held result is all ones with tag bit 1, and `sdo` is 1.
- R2: On every clock edge with `cs_n` high, the frame is reloaded from the held result. On the next cycle `sdo` shows the MSB of the held result as it was before that edge.
- R3: With `tag_en` 0, the first 16 bits shifted out after `cs_n` falls are the held result, MSB first.
- R4: With `chain_en` 1, `tag_en` 0 and `cs_n` low, each `chain_in` bit sampled on a clock edge appears on `sdo` exactly 16 edges later. It therefore follows directly after the local word.
- R5: With `tag_en` 1, the frame is 24 bits: the result MSB first, then the tag bit (0 for channel 0, 1 for channel 1), then seven zeros. The chain delay becomes 24 edges.
- R6: With `chain_en` 0, `chain_in` has no effect. After its own frame, `sdo` repeats that same frame for as long as `cs_n` stays low.
- R7: Raising `cs_n` for one or more edges between words restarts output at the MSB of the held result, so the same word is read again.
- R8: The held result and tag change only on an edge where `result_load` is 1. With no load, a new read returns the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; one rising edge per bit step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| chain_en | input | 1 | 1: chain mode, status pin used as chain input; 0: regular mode |
| tag_en | input | 1 | 1: 24-bit frame with channel tag; 0: 16-bit frame |
| chain_in | input | 1 | Serial data from the upstream converter |
| result_load | input | 1 | Loads `result_word` and `result_tag` into the held result |
| result_word | input | RES_W | New conversion result |
| result_tag | input | 1 | Channel of the new result |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with its defaults: a 16-bit result and an 8-bit tag tail, so frames are 16 or 24 bits. A queue model compares `sdo` every cycle. Pseudo-random chain input makes both the 16- and 24-edge chain delays visible. Runs of more than two frames expose the regular-mode repetition. Chip-select pulses between words and loads placed while chip select is low or high reach the reload and holding corner cases.

// File: rtl/chain_out_pkg.sv
package chain_out_pkg;

  // What the frame register does on a bit step
  typedef enum logic {
    ACT_LOAD  = 1'b0,
    ACT_SHIFT = 1'b1
  } shift_act_e;

endpackage

// File: rtl/chain_out_hold.sv
module chain_out_hold #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] word_in,
  input  logic             tag_in,
  output logic [RES_W-1:0] word_q,
  output logic             tag_q
);

  logic [RES_W-1:0] word_d;
  logic             tag_d;

  always_comb begin
    word_d = word_q;
    tag_d  = tag_q;
    if (load) begin
      word_d = word_in;
      tag_d  = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '1;
      tag_q  <= 1'b1;
    end else if (load) begin
      word_q <= word_d;
      tag_q  <= tag_d;
    end
  end

endmodule

// File: rtl/chain_out_frame.sv
module chain_out_frame #(
  parameter int RES_W = 16,
  parameter int PAD_W = 8,
  localparam int FRAME_W = RES_W + PAD_W
) (
  input  logic [RES_W-1:0]   hold_word,
  input  logic               hold_tag,
  input  logic               tag_en,
  output logic [FRAME_W-1:0] frame
);

  logic [PAD_W-1:0] tail;

  generate
    if (PAD_W > 1) begin : g_wide_tail
      assign tail = tag_en ? {hold_tag, {(PAD_W-1){1'b0}}} : '0;
    end else begin : g_bit_tail
      assign tail = tag_en ? hold_tag : 1'b0;
    end
  endgenerate

  assign frame = {hold_word, tail};

endmodule

// File: rtl/chain_out_shift.sv
module chain_out_shift
  import chain_out_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int PAD_W = 8,
  localparam int FRAME_W = RES_W + PAD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               chain_en,
  input  logic               tag_en,
  input  logic               chain_in,
  input  logic [FRAME_W-1:0] frame,
  output logic [FRAME_W-1:0] shift_q,
  output logic               sdo
);

  shift_act_e         act;
  logic               feed;
  logic [FRAME_W-1:0] shift_d;

  assign act  = cs_n ? ACT_LOAD : ACT_SHIFT;
  // Regular mode recirculates the outgoing bit; chain mode takes upstream data
  assign feed = chain_en ? chain_in : shift_q[FRAME_W-1];

  always_comb begin
    shift_d = shift_q;
    case (act)
      ACT_LOAD: shift_d = frame;
      ACT_SHIFT: begin
        shift_d = {shift_q[FRAME_W-2:0], 1'b0};
        // Entry point sits one word below the output: 24 or 16 bits deep
        if (tag_en) shift_d[0]     = feed;
        else        shift_d[PAD_W] = feed;
      end
      default: shift_d = shift_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= shift_d;
  end

  assign sdo = shift_q[FRAME_W-1];

endmodule

// File: rtl/chain_out_reg.sv
module chain_out_reg #(
  parameter int RES_W = 16,
  parameter int PAD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             chain_en,
  input  logic             tag_en,
  input  logic             chain_in,
  input  logic             result_load,
  input  logic [RES_W-1:0] result_word,
  input  logic             result_tag,
  output logic             sdo
);

  localparam int FRAME_W = RES_W + PAD_W;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [RES_W-1:0]   hold_word;
  logic               hold_tag;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  chain_out_hold #(.RES_W(RES_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (result_load),
    .word_in (result_word),
    .tag_in  (result_tag),
    .word_q  (hold_word),
    .tag_q   (hold_tag)
  );

  chain_out_frame #(.RES_W(RES_W), .PAD_W(PAD_W)) i_frame (
    .hold_word (hold_word),
    .hold_tag  (hold_tag),
    .tag_en    (tag_en),
    .frame     (frame)
  );

  chain_out_shift #(.RES_W(RES_W), .PAD_W(PAD_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_n     (cs_n),
    .chain_en (chain_en),
    .tag_en   (tag_en),
    .chain_in (chain_in),
    .frame    (frame),
    .shift_q  (shift_q),
    .sdo      (sdo)
  );

endmodule

// File: rtl/chain_out_chk.sv
module chain_out_chk #(
  parameter int RES_W = 16,
  parameter int PAD_W = 8,
  localparam int FRAME_W = RES_W + PAD_W
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               cs_n,
  input logic               chain_en,
  input logic               tag_en,
  input logic               chain_in,
  input logic               result_load,
  input logic [RES_W-1:0]   hold_word,
  input logic [FRAME_W-1:0] shift_q,
  input logic               sdo
);

  logic entry_bit;
  assign entry_bit = tag_en ? shift_q[0] : shift_q[PAD_W];

  // R1
  reset_ones_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> sdo == 1'b1);

  // R2
  reload_msb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |=> sdo == $past(hold_word[RES_W-1]));

  // R4
  chain_entry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cs_n && chain_en) ##1 (!cs_n && chain_en && $stable(tag_en))
      |-> entry_bit == $past(chain_in));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !result_load |=> $stable(hold_word));

endmodule

bind chain_out_reg chain_out_chk #(.RES_W(RES_W), .PAD_W(PAD_W)) i_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .cs_n        (cs_n),
  .chain_en    (chain_en),
  .tag_en      (tag_en),
  .chain_in    (chain_in),
  .result_load (result_load),
  .hold_word   (hold_word),
  .shift_q     (shift_q),
  .sdo         (sdo)
);

// File: tb/test_chain_out_reg.sv
`timescale 1ns/1ps
module test_chain_out_reg;

  localparam int RES_W = 16;
  localparam int PAD_W = 8;

  logic             clk;
  logic             rst_n;
  logic             cs_n;
  logic             chain_en;
  logic             tag_en;
  logic             chain_in;
  logic             result_load;
  logic [RES_W-1:0] result_word;
  logic             result_tag;
  logic             sdo;

  int    vectors = 0;
  int    misses  = 0;
  bit    done    = 0;
  string phase   = "R1 reset";

  // Reference state
  bit               mq[$];
  bit [RES_W-1:0]   m_word;
  bit               m_tag;
  logic [15:0]      lfsr = 16'hACE1;

  chain_out_reg #(.RES_W(RES_W), .PAD_W(PAD_W)) i_chain_out_reg (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chain_en(chain_en),
    .tag_en(tag_en), .chain_in(chain_in), .result_load(result_load),
    .result_word(result_word), .result_tag(result_tag), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural model: a queue whose head is the next bit on sdo
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < RES_W + PAD_W; i++) mq.push_back(1'b1);
      m_word = '1;
      m_tag  = 1'b1;
    end else begin
      if (cs_n) begin
        mq.delete();
        for (int i = RES_W-1; i >= 0; i--) mq.push_back(m_word[i]);
        if (tag_en) begin
          mq.push_back(m_tag);
          for (int i = 1; i < PAD_W; i++) mq.push_back(1'b0);
        end
      end else begin
        bit nb;
        nb = chain_en ? chain_in : mq[0];
        void'(mq.pop_front());
        mq.push_back(nb);
      end
      if (result_load) begin
        m_word = result_word;
        m_tag  = result_tag;
      end
    end
  end

  task automatic compare();
    vectors++;
    if (sdo !== mq[0]) begin
      misses++;
      $display("FAIL %s: sdo=%b expected=%b at %0t", phase, sdo, mq[0], $time);
    end
  endtask

  task automatic step(input logic cs, input logic ci);
    @(negedge clk);
    compare();
    cs_n        = cs;
    chain_in    = ci;
    result_load = 1'b0;
  endtask

  task automatic rnd_bit(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  task automatic run(input int n, input logic cs);
    for (int k = 0; k < n; k++) begin
      logic b;
      rnd_bit(b);
      step(cs, b);
    end
  endtask

  task automatic load_result(input logic [RES_W-1:0] w, input logic t);
    @(negedge clk);
    compare();
    result_word = w;
    result_tag  = t;
    result_load = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; chain_en = 1'b0; tag_en = 1'b0;
    chain_in = 1'b0; result_load = 1'b0; result_word = '0; result_tag = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run(4, 1'b1);

    // R1: read back the reset contents, 16 and 24-bit frames
    phase = "R1 reset contents";
    run(20, 1'b0);
    run(2, 1'b1);
    @(negedge clk); compare(); tag_en = 1'b1;
    run(2, 1'b1);
    run(28, 1'b0);
    run(2, 1'b1);
    @(negedge clk); compare(); tag_en = 1'b0;

    // R8 / R2: load and observe the MSB while deselected
    phase = "R8 load, R2 reload MSB";
    load_result(16'hA5C3, 1'b0);
    run(3, 1'b1);
    load_result(16'h3C5A, 1'b1);
    run(3, 1'b1);

    // R3 / R6: regular mode, chain input toggling but ignored
    phase = "R3 R6 regular mode tag off";
    run(50, 1'b0);
    run(1, 1'b1);

    // R7: chip select pulsed between words
    phase = "R7 reselect rereads word";
    for (int w = 0; w < 3; w++) begin
      run(16, 1'b0);
      run(1, 1'b1);
    end

    // R4: chain mode, 16-bit delay
    phase = "R4 chain delay 16";
    load_result(16'h8001, 1'b0);
    @(negedge clk); compare(); chain_en = 1'b1;
    run(2, 1'b1);
    run(48, 1'b0);
    run(2, 1'b1);

    // R5: tagged frame, chain delay 24
    phase = "R5 tag frame chain delay 24";
    load_result(16'h7E19, 1'b1);
    @(negedge clk); compare(); tag_en = 1'b1;
    run(2, 1'b1);
    run(72, 1'b0);
    run(2, 1'b1);

    phase = "R5 R6 tagged regular repeat";
    @(negedge clk); compare(); chain_en = 1'b0;
    run(2, 1'b1);
    run(60, 1'b0);
    run(2, 1'b1);

    // R8: no new load -> previous result; load during a read waits for reload
    phase = "R8 previous result kept";
    @(negedge clk); compare(); tag_en = 1'b0; chain_en = 1'b1;
    run(2, 1'b1);
    run(20, 1'b0);
    load_result(16'h0F0F, 1'b0);
    run(20, 1'b0);
    run(2, 1'b1);
    phase = "R8 R2 new result after reload";
    run(24, 1'b0);
    run(3, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule